// File: doc/BRIEF.md
# Row State Collector

This block gathers, for one pixel row, the hit states found by eighteen column groups and condenses them into a short word stream. Each group reports a count of up to six states. For each state it gives a 6-bit offset inside the group's 64 columns and a 2-bit code for the run length. The collector keeps at most nine states for the row. It rebuilds each kept state's absolute column address from the group index and the offset. It then emits a header word followed by one word per kept state.

A row is presented on parallel inputs and is taken in the cycle where `rowValid_i` is high and `busy_o` is low. The block stores the whole row and drops `busy_o` only once the downstream side has taken the final word. Words leave on a valid/ready stream in which `outValid_o` never depends on `outReady_i`. The header tells the consumer how many state words follow. It also carries an overflow flag, which is set when states were discarded or when a group reported that it lost states of its own.

Top module: `row_state_collector`

## Requirements
- R1: While reset is held and right after it, `busy_o` and `outValid_o` are low.
- R2: A row is accepted only in a cycle where `rowValid_i` is high and `busy_o` is low. `busy_o` goes high in the following cycle if the row has states, and falls in the cycle after the last word's handshake. Rows offered while `busy_o` is high are ignored.
- R3: The first word of a row is the header. Bit 15 is 1, bits 9:0 are the row number, bits 13:10 are the number of state words that follow, and bit 14 is the overflow flag.
- R4: A state word has bit 15 at 0 and bits 14:13 at 0. Bits 12:2 hold the absolute column and bits 1:0 the length code.
- R5: Slot s of group g is read from `grpSlots_i[(g*6+s)*8 +: 8]`, with the offset in the low 6 bits and the length code in the high 2 bits. Its column is g*64 + offset.
- R6: States are emitted by group in ascending order, and by slot in ascending order within a group. Only the first `grpCount_i[g*3 +: 3]` slots of each group are used.
- R7: No more than nine state words follow a header. When the row holds more than nine states, the first nine in R6 order are kept and the overflow flag is set.
- R8: A high bit in `grpOvf_i` sets the row's overflow flag, even when nine or fewer states are present.
- R9: A row whose counts are all zero produces no words and leaves `busy_o` low, whatever `grpOvf_i` holds.
- R10: A group count of seven is treated as six.
- R11: While `outValid_o` is high and `outReady_i` is low, `outValid_o` stays high and `outWord_o` keeps its value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowValid_i | input | 1 | A row is offered this cycle |
| rowNum_i | input | 10 | Row number |
| grpCount_i | input | 54 | Per-group state count, 3 bits per group |
| grpSlots_i | input | 864 | Per-group slots, 8 bits per slot, 6 slots per group |
| grpOvf_i | input | 18 | Per-group lost-state flag |
| busy_o | output | 1 | A row is held and not fully emitted |
| outValid_o | output | 1 | Output word valid |
| outReady_i | input | 1 | Downstream takes the word |
| outWord_o | output | 16 | Header or state word |

## Verification
The assertions rely on the stream rule that the consumer may hold `outReady_i` low for any length of time. They rely on nothing about the row inputs outside the accepting cycle. They also assume that reset is applied once at the start. The stimulus offers real rows only when the reference model is idle. While the block is busy, it drives random rows with `rowValid_i` high, so any wrongful capture would show up as a wrong word later. Group counts include the value seven, to cover the clamp. `outReady_i` toggles at random, with long stretches where it stays high.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef struct packed {
    logic load;
    logic selHeader;
    logic advSlot;
    logic advGroup;
  } rscStrobe_t;

  typedef struct packed {
    logic rowHasStates;
    logic slotHit;
    logic lastKept;
  } rscStatus_t;

endpackage

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int NUM_GROUPS = 18,
  parameter int SLOTS      = 6,
  parameter int GROUP_COLS = 64,
  parameter int MAX_KEPT   = 9,
  parameter int ROW_W      = 10,
  parameter int LEN_W      = 2,
  localparam int OFF_W     = $clog2(GROUP_COLS),
  localparam int SLOT_W    = LEN_W + OFF_W,
  localparam int CNT_W     = $clog2(SLOTS + 1),
  localparam int KEPT_W    = $clog2(MAX_KEPT + 1),
  localparam int COL_W     = $clog2(NUM_GROUPS * GROUP_COLS),
  localparam int WORD_W    = 2 + KEPT_W + ROW_W
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  rscStrobe_t                        strobe,
  output rscStatus_t                        status,
  input  logic [ROW_W-1:0]                  rowNum_i,
  input  logic [NUM_GROUPS*CNT_W-1:0]       grpCount_i,
  input  logic [NUM_GROUPS*SLOTS*SLOT_W-1:0] grpSlots_i,
  input  logic [NUM_GROUPS-1:0]             grpOvf_i,
  output logic [WORD_W-1:0]                 word_o
);

  localparam int NSLOT  = NUM_GROUPS * SLOTS;
  localparam int GIDX_W = $clog2(NUM_GROUPS);
  localparam int SIDX_W = $clog2(SLOTS);
  localparam int IDX_W  = $clog2(NSLOT);
  localparam int TOT_W  = $clog2(NSLOT + 1);

  logic [CNT_W-1:0]  clampCnt [NUM_GROUPS];
  logic [TOT_W-1:0]  total;
  logic [KEPT_W-1:0] keptNext;
  logic              ovfNext;

  logic [ROW_W-1:0]  rowReg;
  logic [KEPT_W-1:0] keptReg;
  logic              ovfReg;
  logic [GIDX_W-1:0] gIdx;
  logic [SIDX_W-1:0] sIdx;
  logic [KEPT_W-1:0] emitCnt;
  logic [CNT_W-1:0]  cntReg [NUM_GROUPS];
  logic [SLOT_W-1:0] slotReg [NSLOT];

  logic [IDX_W-1:0]  slotIdx;
  logic [SLOT_W-1:0] curSlot;
  logic [COL_W-1:0]  absCol;
  logic [WORD_W-1:0] headerWord;
  logic [WORD_W-1:0] stateWord;

  // per-group count clamp
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_clamp
    assign clampCnt[g] = (grpCount_i[g*CNT_W +: CNT_W] > CNT_W'(SLOTS))
                       ? CNT_W'(SLOTS) : grpCount_i[g*CNT_W +: CNT_W];
  end

  always_comb begin
    total = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      total = total + TOT_W'(clampCnt[g]);
    end
  end

  assign keptNext = (total > TOT_W'(MAX_KEPT)) ? KEPT_W'(MAX_KEPT) : total[KEPT_W-1:0];
  assign ovfNext  = (total > TOT_W'(MAX_KEPT)) | (|grpOvf_i);

  // scan pointers and row header fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg  <= '0;
      keptReg <= '0;
      ovfReg  <= 1'b0;
      gIdx    <= '0;
      sIdx    <= '0;
      emitCnt <= '0;
    end else if (strobe.load) begin
      rowReg  <= rowNum_i;
      keptReg <= keptNext;
      ovfReg  <= ovfNext;
      gIdx    <= '0;
      sIdx    <= '0;
      emitCnt <= '0;
    end else if (strobe.advSlot) begin
      sIdx    <= sIdx + SIDX_W'(1);
      emitCnt <= emitCnt + KEPT_W'(1);
    end else if (strobe.advGroup) begin
      gIdx    <= gIdx + GIDX_W'(1);
      sIdx    <= '0;
    end
  end

  // row storage, captured on acceptance only
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        cntReg[g] <= clampCnt[g];
      end
      for (int i = 0; i < NSLOT; i++) begin
        slotReg[i] <= grpSlots_i[i*SLOT_W +: SLOT_W];
      end
    end
  end

  assign slotIdx = IDX_W'(gIdx) * IDX_W'(SLOTS) + IDX_W'(sIdx);
  assign curSlot = slotReg[slotIdx];
  assign absCol  = COL_W'(gIdx) * COL_W'(GROUP_COLS) + COL_W'(curSlot[OFF_W-1:0]);

  assign headerWord = {1'b1, ovfReg, keptReg, rowReg};
  assign stateWord  = WORD_W'({absCol, curSlot[SLOT_W-1:OFF_W]});
  assign word_o     = strobe.selHeader ? headerWord : stateWord;

  assign status.rowHasStates = (total != '0);
  assign status.slotHit      = (CNT_W'(sIdx) < cntReg[gIdx]);
  assign status.lastKept     = ((emitCnt + KEPT_W'(1)) == keptReg);

endmodule

// File: rtl/rsc_control.sv
module rsc_control
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowValid_i,
  input  logic       outReady_i,
  input  rscStatus_t status,
  output rscStrobe_t strobe,
  output logic       busy_o,
  output logic       outValid_o
);

  typedef enum logic [1:0] {IDLE, HEADER, SCAN} rscState_e;

  rscState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt   = state;
    strobe     = '0;
    outValid_o = 1'b0;
    unique case (state)
      IDLE: begin
        if (rowValid_i) begin
          strobe.load = 1'b1;
          if (status.rowHasStates) stateNxt = HEADER;
        end
      end
      HEADER: begin
        outValid_o       = 1'b1;
        strobe.selHeader = 1'b1;
        if (outReady_i) stateNxt = SCAN;
      end
      SCAN: begin
        if (status.slotHit) begin
          outValid_o = 1'b1;
          if (outReady_i) begin
            strobe.advSlot = 1'b1;
            if (status.lastKept) stateNxt = IDLE;
          end
        end else begin
          strobe.advGroup = 1'b1;
        end
      end
      default: stateNxt = IDLE;
    endcase
  end

  assign busy_o = (state != IDLE);

endmodule

// File: rtl/row_state_collector.sv
module row_state_collector
  import rsc_pkg::*;
#(
  parameter int NUM_GROUPS = 18,
  parameter int SLOTS      = 6,
  parameter int GROUP_COLS = 64,
  parameter int MAX_KEPT   = 9,
  parameter int ROW_W      = 10,
  parameter int LEN_W      = 2,
  localparam int OFF_W     = $clog2(GROUP_COLS),
  localparam int SLOT_W    = LEN_W + OFF_W,
  localparam int CNT_W     = $clog2(SLOTS + 1),
  localparam int KEPT_W    = $clog2(MAX_KEPT + 1),
  localparam int WORD_W    = 2 + KEPT_W + ROW_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               rowValid_i,
  input  logic [ROW_W-1:0]                   rowNum_i,
  input  logic [NUM_GROUPS*CNT_W-1:0]        grpCount_i,
  input  logic [NUM_GROUPS*SLOTS*SLOT_W-1:0] grpSlots_i,
  input  logic [NUM_GROUPS-1:0]              grpOvf_i,
  output logic                               busy_o,
  output logic                               outValid_o,
  input  logic                               outReady_i,
  output logic [WORD_W-1:0]                  outWord_o
);

  rscStrobe_t strobe;
  rscStatus_t status;

  rsc_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rowValid_i (rowValid_i),
    .outReady_i (outReady_i),
    .status     (status),
    .strobe     (strobe),
    .busy_o     (busy_o),
    .outValid_o (outValid_o)
  );

  rsc_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .SLOTS      (SLOTS),
    .GROUP_COLS (GROUP_COLS),
    .MAX_KEPT   (MAX_KEPT),
    .ROW_W      (ROW_W),
    .LEN_W      (LEN_W)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .status     (status),
    .rowNum_i   (rowNum_i),
    .grpCount_i (grpCount_i),
    .grpSlots_i (grpSlots_i),
    .grpOvf_i   (grpOvf_i),
    .word_o     (outWord_o)
  );

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int NUM_GROUPS = 18,
  parameter int GROUP_COLS = 64,
  parameter int MAX_KEPT   = 9,
  parameter int ROW_W      = 10,
  parameter int LEN_W      = 2,
  parameter int WORD_W     = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy_o,
  input logic              outValid_o,
  input logic              outReady_i,
  input logic [WORD_W-1:0] outWord_o
);

  localparam int KEPT_W = $clog2(MAX_KEPT + 1);
  localparam int COL_W  = $clog2(NUM_GROUPS * GROUP_COLS);

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid_o && !outReady_i |=> outValid_o && $stable(outWord_o));

  // R2
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid_o |-> busy_o);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy_o && !(outValid_o && outReady_i) |=> busy_o);

  // R3
  header_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy_o) |-> outValid_o && outWord_o[WORD_W-1]);

  // R7
  kept_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid_o && outWord_o[WORD_W-1] |-> outWord_o[ROW_W +: KEPT_W] <= KEPT_W'(MAX_KEPT));

  // R9
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid_o && outWord_o[WORD_W-1] |-> outWord_o[ROW_W +: KEPT_W] != '0);

  // R5
  col_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid_o && !outWord_o[WORD_W-1]
      |-> outWord_o[LEN_W +: COL_W] < COL_W'(NUM_GROUPS * GROUP_COLS));

endmodule

bind row_state_collector rsc_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .GROUP_COLS (GROUP_COLS),
  .MAX_KEPT   (MAX_KEPT),
  .ROW_W      (ROW_W),
  .LEN_W      (LEN_W),
  .WORD_W     (WORD_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busy_o     (busy_o),
  .outValid_o (outValid_o),
  .outReady_i (outReady_i),
  .outWord_o  (outWord_o)
);

// File: tb/sim_row_state_collector.sv
module sim_row_state_collector;

  localparam int NG = 18;
  localparam int NS = 6;
  localparam int SW = 8;
  localparam int NROWS = 220;
  localparam int LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rowValid;
  logic [9:0]        rowNum;
  logic [NG*3-1:0]   grpCount;
  logic [NG*NS*SW-1:0] grpSlots;
  logic [NG-1:0]     grpOvf;
  logic              busy;
  logic              outValid;
  logic              outReady;
  logic [15:0]       outWord;

  always #10 clk = ~clk;

  row_state_collector u0 (
    .clk        (clk),
    .rstN       (rstN),
    .rowValid_i (rowValid),
    .rowNum_i   (rowNum),
    .grpCount_i (grpCount),
    .grpSlots_i (grpSlots),
    .grpOvf_i   (grpOvf),
    .busy_o     (busy),
    .outValid_o (outValid),
    .outReady_i (outReady),
    .outWord_o  (outWord)
  );

  int vectors = 0;
  int misses  = 0;
  logic [15:0] expQ [$];
  string       tagQ [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic setSlot(input int g, input int s, input int off, input int len);
    grpSlots[(g*NS+s)*SW +: SW] = {len[1:0], off[5:0]};
  endtask

  task automatic setCnt(input int g, input int c);
    grpCount[g*3 +: 3] = c[2:0];
  endtask

  task automatic randomFill();
    rowNum = 10'($urandom);
    for (int i = 0; i < NG*NS; i++) grpSlots[i*SW +: SW] = 8'($urandom);
    for (int g = 0; g < NG; g++) grpCount[g*3 +: 3] = 3'($urandom);
    grpOvf = 18'($urandom);
  endtask

  task automatic buildRow(input int k);
    rowNum   = 10'($urandom);
    grpCount = '0;
    grpOvf   = '0;
    for (int i = 0; i < NG*NS; i++) grpSlots[i*SW +: SW] = 8'($urandom);
    case (k)
      0: ;
      1: begin setCnt(17, 1); setSlot(17, 0, 63, 3); end
      2: setCnt(0, 6);
      3: begin setCnt(1, 3); setCnt(5, 2); setCnt(9, 4); end
      4: begin setCnt(2, 5); setCnt(3, 5); end
      5: for (int g = 0; g < NG; g++) setCnt(g, 6);
      6: begin setCnt(4, 2); grpOvf[11] = 1'b1; end
      7: grpOvf = 18'h3ffff;
      8: begin setCnt(3, 7); setCnt(6, 1); end
      default: begin
        for (int g = 0; g < NG; g++) begin
          if ($urandom % 8 >= 5) setCnt(g, ($urandom % 7) + 1);
        end
        if ($urandom % 16 == 0) grpOvf[$urandom % NG] = 1'b1;
      end
    endcase
  endtask

  bit zeroPending;

  task automatic modelRow();
    int tot = 0;
    int kept, n;
    bit clamp = 0;
    bit ov;
    int c [NG];
    string hTag, sTag;
    for (int g = 0; g < NG; g++) begin
      c[g] = int'(grpCount[g*3 +: 3]);
      if (c[g] > 6) begin c[g] = 6; clamp = 1; end
      tot += c[g];
    end
    if (tot == 0) begin
      zeroPending = 1;
      return;
    end
    kept = (tot > 9) ? 9 : tot;
    ov   = (tot > 9) || (|grpOvf);
    hTag = clamp ? "R10" : (|grpOvf) ? "R8" : (tot > 9) ? "R7" : "R3";
    sTag = clamp ? "R10" : (tot > 9) ? "R7" : "R4 R5 R6";
    expQ.push_back({1'b1, ov, 4'(kept), rowNum});
    tagQ.push_back(hTag);
    n = 0;
    for (int g = 0; g < NG; g++) begin
      for (int s = 0; s < c[g]; s++) begin
        if (n < kept) begin
          logic [7:0] sl;
          sl = grpSlots[(g*NS+s)*SW +: SW];
          expQ.push_back({3'b000, 11'(g*64 + int'(sl[5:0])), sl[7:6]});
          tagQ.push_back(sTag);
          n++;
        end
      end
    end
  endtask

  initial begin
    int rowsSent = 0;
    int cyc = 0;
    bit prevV = 0, prevR = 0;
    logic [15:0] prevW = '0;
    bit modelBusy;

    rstN = 1'b0;
    rowValid = 1'b0;
    outReady = 1'b0;
    rowNum = '0; grpCount = '0; grpSlots = '0; grpOvf = '0;
    zeroPending = 0;
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "busy in reset", 32'(busy), 0);
    chk(!outValid, "R1", "valid in reset", 32'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !outValid, "R1", "idle after reset", {busy, outValid}, 0);

    while ((rowsSent < NROWS || expQ.size() != 0) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      modelBusy = (expQ.size() != 0);
      chk(busy == modelBusy, "R2", "busy", 32'(busy), 32'(modelBusy));
      if (zeroPending) begin
        chk(!busy && !outValid, "R9", "empty row output", {busy, outValid}, 0);
        zeroPending = 0;
      end
      if (prevV && !prevR)
        chk(outValid && outWord == prevW, "R11", "held word", {outValid, outWord}, {1'b1, prevW});
      if (outValid) begin
        if (expQ.size() == 0) chk(0, "R9", "unexpected word", 32'(outWord), 0);
        else chk(outWord == expQ[0], tagQ[0], "word", 32'(outWord), 32'(expQ[0]));
      end
      outReady = ((rowsSent / 20) % 2 == 1) ? 1'b1 : ($urandom % 10 < 6);
      if (outValid && outReady && expQ.size() != 0) begin
        void'(expQ.pop_front());
        void'(tagQ.pop_front());
      end
      if (!modelBusy && rowsSent < NROWS && ($urandom % 4 != 0)) begin
        buildRow(rowsSent);
        rowValid = 1'b1;
        modelRow();
        rowsSent++;
      end else if (modelBusy && ($urandom % 2 == 0)) begin
        randomFill();
        rowValid = 1'b1;
      end else begin
        rowValid = 1'b0;
      end
      prevV = outValid;
      prevR = outReady;
      prevW = outWord;
    end

    if (cyc >= LIMIT) chk(0, "R2", "watchdog expired", 32'(cyc), LIMIT);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule